// File: doc/BRIEF.md
# Burst Column Sequencer with Read/Write Mask Timing

This block sits between a synchronous memory's command decoder and its storage array. When a read or write command arrives, it produces one column address per clock for the whole burst. The burst length, the wrap order and the CAS latency come from mode inputs. Alongside each address it states whether the access is a write. It gates each write access with the byte-mask input in the same cycle, so a masked word is never written.

Read accesses enter a shift pipeline, so the read-data-valid flag rises exactly CAS latency cycles after each read access. The output enable is that valid flag, qualified by the mask input sampled two cycles earlier. An optional mode shortens this to one cycle, but only when CAS latency is 1.

A burst-stop command, or a precharge command, ends the burst: no access is issued in its cycle or after it. Read data that is already in flight still emerges, so a read ends exactly CAS latency cycles after the stop. A write ends at once. A new read or write that arrives during a burst cuts the old one short and starts over.

Top module: `burst_seq`

## Requirements
- R1: The 3-bit length code gives the number of accesses per burst: 0→1, 1→2, 2→4, 3→8. Code 7 gives an endless full page in sequential order. Code 7 in interleaved order, and codes 4–6, are treated as length 1. `col_wr` is 1 on each access of a write burst and 0 on each access of a read burst.
- R2: In sequential order (`il_mode`=0), access k of a burst of length L uses the start column with its low log2(L) bits replaced by (start+k) mod L. The burst therefore wraps inside the aligned block of L columns.
- R3: In interleaved order (`il_mode`=1), access k uses the start column XOR k.
- R4: A full-page burst issues (start+k) mod 2^COL_W and continues until it is ended by a stop or a new command.
- R5: `rd_vld` is 1 exactly CL cycles after each read access, and at no other time. CL is `cl_code` for codes 1 to MAX_CL; every other code, including 0, acts as MAX_CL.
- R6: `rd_oe` equals `rd_vld` AND NOT the value `dqm` had two cycles earlier.
- R7: When `dqm_short`=1 and the effective CL is 1, `rd_oe` uses the `dqm` value from one cycle earlier instead.
- R8: `wr_en` is 1 exactly in cycles that carry a write access and in which `dqm` is 0 (zero-cycle mask latency).
- R9: In the cycle `stop_cmd` is sampled, and afterwards, no access is issued and `wr_en` is 0. Read accesses issued before the stop still produce `rd_vld` CL cycles later.
- R10: A read or write command during a burst issues its own start column in that cycle and continues with its own burst. The old burst issues nothing further.
- R11: After reset, and with no command applied, `col_vld`, `col_wr`, `wr_en`, `rd_vld` and `rd_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | Decoded read command |
| wr_cmd | input | 1 | Decoded write command (wins over rd_cmd) |
| stop_cmd | input | 1 | Decoded burst-stop or precharge |
| start_col | input | COL_W | Starting column, sampled with the command |
| bl_code | input | 3 | Burst length code |
| il_mode | input | 1 | 0 sequential, 1 interleaved order |
| cl_code | input | 3 | CAS latency code |
| dqm_short | input | 1 | Enables one-cycle read mask latency when CL is 1 |
| dqm | input | 1 | Data mask |
| col_addr | output | COL_W | Column for the current access |
| col_vld | output | 1 | An access is issued this cycle |
| col_wr | output | 1 | The current access is a write |
| wr_en | output | 1 | Write strobe after masking |
| rd_vld | output | 1 | Read data present on the bus this cycle |
| rd_oe | output | 1 | Output driver enable |

## Verification
The bench uses COL_W=8 and MAX_CL=3. With these values a full page is 256 columns, short enough to run past its wrap. The sweep crosses every CAS latency with both mask-latency settings, all legal length codes in both orders, both directions, and start columns that sit at or near block edges. Reserved length and latency codes are also exercised. Stops at several offsets and a mid-burst command switch cover termination and truncation. The mask input changes with a pattern, so each mask latency shows up as a shift in the enable.

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq #(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd,
  input  logic             wr_cmd,
  input  logic             stop_cmd,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             il_mode,
  input  logic [2:0]       cl_code,
  input  logic             dqm_short,
  input  logic             dqm,
  output logic [COL_W-1:0] col_addr,
  output logic             col_vld,
  output logic             col_wr,
  output logic             wr_en,
  output logic             rd_vld,
  output logic             rd_oe
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] st_q, k_q, mask_q;
  logic             act_q, wr_q, il_q, full_q;
  logic [COL_W-1:0] new_mask;
  logic             new_full, new_cmd;
  logic [COL_W-1:0] cur_st, cur_k, cur_mask;
  logic             cur_il, cur_wr, cur_full, last;
  logic [MAX_CL-1:0] rd_pipe;
  logic [1:0]       dqm_d;
  int               cl_eff;

  assign new_cmd  = rd_cmd | wr_cmd;
  assign new_full = (bl_code == 3'd7) && !il_mode;

  always_comb begin
    case (bl_code)
      3'd1:    new_mask = COL_W'(1);
      3'd2:    new_mask = COL_W'(3);
      3'd3:    new_mask = COL_W'(7);
      3'd7:    new_mask = il_mode ? '0 : '1;
      default: new_mask = '0;
    endcase
  end

  assign cur_st   = new_cmd ? start_col : st_q;
  assign cur_k    = new_cmd ? '0        : k_q;
  assign cur_mask = new_cmd ? new_mask  : mask_q;
  assign cur_il   = new_cmd ? il_mode   : il_q;
  assign cur_wr   = new_cmd ? wr_cmd    : wr_q;
  assign cur_full = new_cmd ? new_full  : full_q;

  assign col_vld  = new_cmd | (act_q & ~stop_cmd);
  assign col_wr   = col_vld & cur_wr;
  assign col_addr = cur_il ? (cur_st ^ cur_k)
                           : ((cur_st & ~cur_mask) | ((cur_st + cur_k) & cur_mask));
  assign last     = (cur_k == cur_mask) & ~cur_full;
  assign wr_en    = col_wr & ~dqm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0; k_q <= '0; mask_q <= '0;
      act_q <= 1'b0; wr_q <= 1'b0; il_q <= 1'b0; full_q <= 1'b0;
    end else if (col_vld) begin
      k_q   <= cur_k + ONE;
      act_q <= ~last;
      if (new_cmd) begin
        st_q   <= start_col;
        mask_q <= new_mask;
        il_q   <= il_mode;
        wr_q   <= wr_cmd;
        full_q <= new_full;
      end
    end else begin
      act_q <= 1'b0;
    end
  end

  always_comb begin
    if (cl_code != 3'd0 && int'(cl_code) <= MAX_CL) cl_eff = int'(cl_code);
    else                                            cl_eff = MAX_CL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pipe <= '0;
      dqm_d   <= '0;
    end else begin
      rd_pipe <= {rd_pipe[MAX_CL-2:0], col_vld & ~cur_wr};
      dqm_d   <= {dqm_d[0], dqm};
    end
  end

  always_comb begin
    rd_vld = 1'b0;
    for (int i = 1; i <= MAX_CL; i++)
      if (cl_eff == i) rd_vld = rd_pipe[i-1];
  end

  assign rd_oe = rd_vld & ~((dqm_short && cl_eff == 1) ? dqm_d[0] : dqm_d[1]);
endmodule

module burst_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_cmd,
  input logic             wr_cmd,
  input logic             stop_cmd,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       cl_code,
  input logic             dqm_short,
  input logic             dqm,
  input logic [COL_W-1:0] col_addr,
  input logic             col_vld,
  input logic             col_wr,
  input logic             wr_en,
  input logic             rd_vld,
  input logic             rd_oe
);
  a_r10_cmd_starts_at_col: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd || wr_cmd) |-> (col_vld && col_addr == start_col && col_wr == wr_cmd));

  a_r9_stop_issues_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && !rd_cmd && !wr_cmd) |-> (!col_vld && !wr_en));

  a_r8_write_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (col_wr && !dqm));

  a_r5_cl1_data: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && !col_wr && cl_code == 3'd1) |=> rd_vld);

  a_r5_cl2_data: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && !col_wr && cl_code == 3'd2) |=> ##1 rd_vld);

  a_r6_oe_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> rd_vld);

  a_r7_short_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && dqm_short && cl_code == 3'd1 && $past(dqm)) |-> !rd_oe);
endmodule

bind burst_seq burst_seq_chk #(.COL_W(COL_W)) chk_i (.*);

// File: tb/burst_seq_tb_top.sv
`timescale 1ns/1ps
module burst_seq_tb_top;
  localparam int COL_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_cmd = 0, wr_cmd = 0, stop_cmd = 0, il_mode = 0, dqm_short = 0, dqm = 0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] bl_code = '0, cl_code = 3'd1;
  logic [COL_W-1:0] col_addr;
  logic col_vld, col_wr, wr_en, rd_vld, rd_oe;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_seq #(.COL_W(COL_W), .MAX_CL(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .stop_cmd(stop_cmd),
    .start_col(start_col), .bl_code(bl_code), .il_mode(il_mode), .cl_code(cl_code),
    .dqm_short(dqm_short), .dqm(dqm), .col_addr(col_addr), .col_vld(col_vld),
    .col_wr(col_wr), .wr_en(wr_en), .rd_vld(rd_vld), .rd_oe(rd_oe));

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int blen(int code, bit il);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return il ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  function automatic int eff_cl(int code);
    return (code >= 1 && code <= 3) ? code : 3;
  endfunction

  function automatic bit dq_pat(int c, int seed);
    if (c < 0) return 1'b0;
    return ((c * 7 + seed) % 5) == 2;
  endfunction

  function automatic int exp_col(int st, int c, int len, bit il);
    int m;
    if (il) return (st ^ c) & 255;
    m = (len == 0) ? 255 : len - 1;
    return (st & ~m & 255) | ((st + c) & m);
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_cmd = 0; wr_cmd = 0; stop_cmd = 0; dqm = 0;
    end
  endtask

  task automatic burst(bit wr, int st, int blc, bit il, int clc, bit fast, int stop_s, int seed);
    int len, issued, cl, lat;
    bit rv, stopped;
    string ctag;
    len = blen(blc, il);
    cl = eff_cl(clc);
    issued = (len == 0) ? stop_s : ((stop_s >= 0 && stop_s < len) ? stop_s : len);
    lat = (fast && cl == 1) ? 1 : 2;
    ctag = il ? "R3" : (len == 0 ? "R4" : "R2");
    @(negedge clk);
    bl_code = 3'(blc); il_mode = il; cl_code = 3'(clc); dqm_short = fast;
    for (int c = 0; c < issued + cl + 3; c++) begin
      @(negedge clk);
      rd_cmd = (c == 0) && !wr;
      wr_cmd = (c == 0) && wr;
      stop_cmd = (c == stop_s);
      start_col = COL_W'(st);
      dqm = dq_pat(c, seed);
      #1;
      stopped = (stop_s >= 0) && (c >= stop_s);
      chk(stopped ? "R9" : "R1", "col_vld", col_vld, c < issued);
      if (c < issued) begin
        chk(ctag, "col_addr", col_addr, exp_col(st, c, len, il));
        chk("R1", "col_wr", col_wr, wr);
      end
      chk(stopped ? "R9" : "R8", "wr_en", wr_en, wr && c < issued && !dq_pat(c, seed));
      rv = !wr && c >= cl && (c - cl) < issued;
      chk(stopped ? "R9" : "R5", "rd_vld", rd_vld, rv);
      chk(lat == 1 ? "R7" : "R6", "rd_oe", rd_oe, rv && !dq_pat(c - lat, seed));
    end
    idle(4);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int bls[5] = '{0, 1, 2, 3, 7};
    int sts[4] = '{0, 5, 13, 250};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R11 reset state
    chk("R11", "col_vld", col_vld, 0);
    chk("R11", "col_wr", col_wr, 0);
    chk("R11", "wr_en", wr_en, 0);
    chk("R11", "rd_vld", rd_vld, 0);
    chk("R11", "rd_oe", rd_oe, 0);

    // sweep: R1 R2 R3 R4 R5 R6 R7 R8
    for (int clc = 1; clc <= 3; clc++)
      for (int f = 0; f < 2; f++)
        for (int b = 0; b < 5; b++)
          for (int il = 0; il < 2; il++)
            for (int w = 0; w < 2; w++)
              for (int s = 0; s < 4; s++)
                burst(w[0], sts[s], bls[b], il[0], clc, f[0],
                      (bls[b] == 7 && il == 0) ? 20 : -1, s + b + clc);

    // R4 full page across the wrap
    burst(1'b0, 200, 7, 1'b0, 2, 1'b0, 260, 4);
    burst(1'b1, 3, 7, 1'b0, 1, 1'b0, 258, 1);

    // reserved length and latency codes: R1 R5
    burst(1'b0, 9, 5, 1'b0, 0, 1'b0, -1, 2);
    burst(1'b0, 77, 4, 1'b1, 6, 1'b1, -1, 3);
    burst(1'b1, 30, 6, 1'b0, 5, 1'b0, -1, 0);

    // R9 termination at several offsets
    for (int clc = 1; clc <= 3; clc++)
      for (int w = 0; w < 2; w++)
        for (int s = 1; s <= 3; s++)
          burst(w[0], 20, 3, 1'b0, clc, 1'b0, s, 3);

    // R10 write cuts a read burst short
    @(negedge clk);
    bl_code = 3'd3; il_mode = 0; cl_code = 3'd2; dqm_short = 0;
    for (int c = 0; c < 13; c++) begin
      @(negedge clk);
      rd_cmd = (c == 0);
      wr_cmd = (c == 3);
      start_col = (c < 3) ? 8'd16 : 8'd40;
      dqm = 0;
      #1;
      chk("R10", "col_vld", col_vld, c < 11);
      if (c < 11) begin
        chk("R10", "col_addr", col_addr, (c < 3) ? 16 + c : 40 + (c - 3));
        chk("R10", "col_wr", col_wr, c >= 3);
      end
      chk("R10", "wr_en", wr_en, c >= 3 && c < 11);
      chk("R10", "rd_vld", rd_vld, c >= 2 && c <= 4);
    end
    idle(4);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule